// File: doc/BRIEF.md
# Dual-Threshold Hit Timestamp Channel

This block is the digital part of one channel of a strip-detector readout chip. It watches two discriminator outputs: one with a low threshold and one with a high threshold. It also receives a free-running timestamp bus that is shared by every channel. All of these live in one fast clock domain. The time resolution is one clock period. At 160 MHz that period is 6.25 ns.

The rising edge of the low-threshold signal marks the time of arrival. The falling edge of the same signal marks the end of the pulse. The pulse width (time over threshold) is the difference between the two captured timestamps. The difference is taken modulo the timestamp width, so it stays correct when the counter wraps between the two edges.

The high threshold serves only as a validation gate. A pulse during which the high-threshold signal never went active is treated as noise and dropped without any output. Each kept hit produces one packed word, which is held on a valid/ready output. Every state register is stored three times and read through a bitwise majority vote, so that a single upset copy is outvoted.

Top module: `dual_thr_hit_channel`

## Requirements
- R1: While reset is low, and after it is released, `hit_valid` is 0 until a complete qualified pulse has been seen. Asserting reset while a word is pending clears `hit_valid`.
- R2: The leading-edge field is the `ts_bus` value sampled on the third rising clock edge after `cmp_lo` is first seen high. The first of those edges is the synchronizer capture edge, so the field equals the value sampled at that capture edge plus 2.
- R3: The ToT field equals the trailing timestamp minus the leading timestamp. Both edges pass through the same delay, so for a pulse of N clock cycles on `cmp_lo` the field is N, including N = 1.
- R4: The subtraction is modulo 2^16, so a pulse during which `ts_bus` wraps from 16'hFFFF to 0 still reports its true width.
- R5: The ToT field saturates at 1023 (all ones) when the width exceeds 1023 cycles.
- R6: If `cmp_hi` is not high in any synchronized cycle from the leading edge through the trailing edge, no word is produced: `hit_valid` stays 0.
- R7: Output word layout: bits [31:26] hold `chan_id`, bits [25:10] hold the leading timestamp, and bits [9:0] hold the ToT.
- R8: While `hit_valid` is 1 and `hit_ready` is 0, `hit_valid` stays 1 and `hit_word` stays unchanged on every later clock edge.
- R9: A new `cmp_lo` rising edge that arrives while a word is pending is ignored: the pending word is not altered, and that pulse never produces a word.
- R10: After a clock edge where `hit_valid` and `hit_ready` are both 1, `hit_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock; all timing is in its periods |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_id | input | 6 | Static channel number packed into each word |
| cmp_lo | input | 1 | Low-threshold discriminator output (asynchronous) |
| cmp_hi | input | 1 | High-threshold discriminator output (asynchronous) |
| ts_bus | input | 16 | Shared free-running timestamp |
| hit_word | output | 32 | Packed hit word |
| hit_valid | output | 1 | Hit word available |
| hit_ready | input | 1 | Consumer accepts the word on a clock edge where both are high |

## Verification
A corrupted leading-timestamp register would appear in bits [25:10] of the next word. It would also shift that word's ToT by the same amount, with the opposite sign, so a single wrong word exposes it about three cycles after the trailing edge. A stuck or mis-set qualification flag would either emit a word for a pulse with no high-threshold activity or swallow a real hit. Either case shows up within four cycles of the falling edge. A control state stuck in the pending state would keep `hit_valid` high after a handshake, which is visible on the very next cycle.

// File: rtl/hitch_pkg.sv
// Package: shared types for the dual-threshold hit channel.
// Assumes nothing beyond the encodings declared here.
package hitch_pkg;

    // Control states of the hit sequencer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_PEND  = 2'd2
    } hit_state_e;

    localparam int STATE_W = 2;

endpackage

// File: rtl/tmr_reg.sv
// Module: tmr_reg
// A W-bit register kept as three identical copies. The output is the bitwise
// majority of the copies, and each copy reloads from the common next value,
// so a single upset copy is outvoted and then rewritten on the next edge.
// Assumes a synchronous active-low reset to RST_VAL.
module tmr_reg #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] copy [3];

    for (genvar g = 0; g < 3; g++) begin : g_copy
        // Load one copy from the shared next value
        always_ff @(posedge clk) begin
            if (!rst_n) copy[g] <= RST_VAL;
            else        copy[g] <= d;
        end
    end

    // Bitwise 2-of-3 vote
    always_comb begin
        q = (copy[0] & copy[1]) | (copy[0] & copy[2]) | (copy[1] & copy[2]);
    end

endmodule

// File: rtl/sync_edge.sv
// Module: sync_edge
// Brings an asynchronous comparator level into the clock domain through
// STAGES flops, then compares the result with its own one-cycle-delayed copy
// to give single-cycle rise and fall pulses. The flop chain is triplicated.
// Assumes the input stays at least one clock period in each state.
module sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);

    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    // Shift the raw input into the chain
    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], din};
    end

    tmr_reg #(.W(CHAIN_W), .RST_VAL('0)) chain_r (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (chain_d),
        .q    (chain_q)
    );

    // Synchronized level and its edges
    always_comb begin
        level = chain_q[STAGES-1];
        rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
        fall  = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

endmodule

// File: rtl/hit_ctrl.sv
// Module: hit_ctrl
// Sequencer for one channel. On a synchronized low-threshold rise it stores
// the shared timestamp and starts tracking the high-threshold level. On the
// low-threshold fall it either packs a word and holds it for the consumer,
// or drops the pulse when the high threshold never fired.
// Assumes TS_W > TOT_W and edge inputs that are single-cycle pulses.
module hit_ctrl
    import hitch_pkg::*;
#(
    parameter int CH_W  = 6,
    parameter int TS_W  = 16,
    parameter int TOT_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CH_W-1:0]              chan_id,
    input  logic [TS_W-1:0]              ts_bus,
    input  logic                         lo_rise,
    input  logic                         lo_fall,
    input  logic                         hi_level,
    input  logic                         out_ready,
    output logic [CH_W+TS_W+TOT_W-1:0]   out_word,
    output logic                         out_valid
);

    localparam int WORD_W = CH_W + TS_W + TOT_W;

    logic [STATE_W-1:0] st_raw_d, st_raw_q;
    hit_state_e         st_q, st_d;
    logic [TS_W-1:0]    lead_d, lead_q;
    logic               hiq_d, hiq_q;
    logic [WORD_W-1:0]  word_d, word_q;
    logic [TS_W-1:0]    width_raw;
    logic [TOT_W-1:0]   tot_sat;

    // Width of the pulse, modulo the timestamp range
    always_comb begin
        width_raw = ts_bus - lead_q;
    end

    // Clamp the width to the ToT field
    if (TS_W > TOT_W) begin : g_clamp
        always_comb begin
            tot_sat = (|width_raw[TS_W-1:TOT_W]) ? {TOT_W{1'b1}} : width_raw[TOT_W-1:0];
        end
    end else begin : g_noclamp
        always_comb begin
            tot_sat = TOT_W'(width_raw);
        end
    end

    // Next-state and capture logic
    always_comb begin
        st_d   = st_q;
        lead_d = lead_q;
        hiq_d  = hiq_q;
        word_d = word_q;
        unique case (st_q)
            ST_IDLE: begin
                if (lo_rise) begin
                    st_d   = ST_PULSE;
                    lead_d = ts_bus;
                    hiq_d  = hi_level;
                end
            end
            ST_PULSE: begin
                hiq_d = hiq_q | hi_level;
                if (lo_fall) begin
                    if (hiq_q | hi_level) begin
                        st_d   = ST_PEND;
                        word_d = {chan_id, lead_q, tot_sat};
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_PEND: begin
                if (out_ready) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Enum to raw bits for the voted register
    always_comb begin
        st_raw_d = STATE_W'(st_d);
        st_q     = hit_state_e'(st_raw_q);
    end

    tmr_reg #(.W(STATE_W), .RST_VAL(STATE_W'(ST_IDLE))) state_r (
        .clk(clk), .rst_n(rst_n), .d(st_raw_d), .q(st_raw_q)
    );

    tmr_reg #(.W(TS_W), .RST_VAL('0)) lead_r (
        .clk(clk), .rst_n(rst_n), .d(lead_d), .q(lead_q)
    );

    tmr_reg #(.W(1), .RST_VAL(1'b0)) hiq_r (
        .clk(clk), .rst_n(rst_n), .d(hiq_d), .q(hiq_q)
    );

    tmr_reg #(.W(WORD_W), .RST_VAL('0)) word_r (
        .clk(clk), .rst_n(rst_n), .d(word_d), .q(word_q)
    );

    // Drive the output handshake from the voted state
    always_comb begin
        out_valid = (st_q == ST_PEND);
        out_word  = word_q;
    end

endmodule

// File: rtl/dual_thr_hit_channel.sv
// Module: dual_thr_hit_channel
// Top level of one readout channel: two synchronizers with edge detection,
// followed by the hit sequencer. Output is a valid/ready word.
// Assumes ts_bus is synchronous to clk and chan_id is static.
module dual_thr_hit_channel #(
    parameter int CH_W      = 6,
    parameter int TS_W      = 16,
    parameter int TOT_W     = 10,
    parameter int SYNC_STGS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CH_W-1:0]             chan_id,
    input  logic                        cmp_lo,
    input  logic                        cmp_hi,
    input  logic [TS_W-1:0]             ts_bus,
    output logic [CH_W+TS_W+TOT_W-1:0]  hit_word,
    output logic                        hit_valid,
    input  logic                        hit_ready
);

    logic lo_level, lo_rise, lo_fall;
    logic hi_level, hi_rise, hi_fall;
    logic unused_edges;

    // Only the high-threshold level is used; its edges are discarded
    always_comb begin
        unused_edges = lo_level ^ hi_rise ^ hi_fall;
    end

    sync_edge #(.STAGES(SYNC_STGS)) lo_sync_i (
        .clk(clk), .rst_n(rst_n), .din(cmp_lo),
        .level(lo_level), .rise(lo_rise), .fall(lo_fall)
    );

    sync_edge #(.STAGES(SYNC_STGS)) hi_sync_i (
        .clk(clk), .rst_n(rst_n), .din(cmp_hi),
        .level(hi_level), .rise(hi_rise), .fall(hi_fall)
    );

    hit_ctrl #(.CH_W(CH_W), .TS_W(TS_W), .TOT_W(TOT_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_id  (chan_id),
        .ts_bus   (ts_bus),
        .lo_rise  (lo_rise),
        .lo_fall  (lo_fall),
        .hi_level (hi_level),
        .out_ready(hit_ready),
        .out_word (hit_word),
        .out_valid(hit_valid)
    );

endmodule

// File: rtl/hitch_chk.sv
// Module: hitch_chk
// Protocol and field checks on the ports of dual_thr_hit_channel, bound below.
module hitch_chk #(
    parameter int CH_W  = 6,
    parameter int TS_W  = 16,
    parameter int TOT_W = 10
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [CH_W-1:0]             chan_id,
    input logic [CH_W+TS_W+TOT_W-1:0]  hit_word,
    input logic                        hit_valid,
    input logic                        hit_ready
);

    localparam int WORD_W = CH_W + TS_W + TOT_W;

    // R8: word held stable until accepted
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && !hit_ready |=> hit_valid && $stable(hit_word));

    // R10: valid drops after the handshake edge
    assert_drop_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && hit_ready |=> !hit_valid);

    // R7: channel field carries the static channel number
    assert_chan_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> hit_word[WORD_W-1 -: CH_W] == chan_id);

    // R3: a kept pulse is at least one cycle wide
    assert_tot_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> hit_word[TOT_W-1:0] != '0);

    // R1: the first cycle out of reset shows no word
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !hit_valid);

endmodule

bind dual_thr_hit_channel hitch_chk #(.CH_W(CH_W), .TS_W(TS_W), .TOT_W(TOT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_id  (chan_id),
    .hit_word (hit_word),
    .hit_valid(hit_valid),
    .hit_ready(hit_ready)
);

// File: tb/dual_thr_hit_channel_tb_top.sv
`timescale 1ns/1ps
module dual_thr_hit_channel_tb_top;

    typedef struct packed {
        logic [15:0] preset;
        logic [15:0] width;
        logic [15:0] hi_at;   // 16'hFFFF: high threshold never fires
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{16'h0100, 16'd5,    16'd0},     // R2 R3 basic
        '{16'h1234, 16'd20,   16'd7},     // R6 hi mid-pulse qualifies
        '{16'hFFF0, 16'd40,   16'd3},     // R4 wrap
        '{16'h0042, 16'd12,   16'hFFFF},  // R6 dropped
        '{16'h7000, 16'd1,    16'd0},     // R3 minimum width
        '{16'h2000, 16'd1100, 16'd100}    // R5 saturation
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  chan_id = 6'h2A;
    logic        cmp_lo = 1'b0, cmp_hi = 1'b0;
    logic [15:0] ts_bus = '0;
    logic        ts_load = 1'b0;
    logic [15:0] ts_val = '0;
    logic [31:0] hit_word;
    logic        hit_valid;
    logic        hit_ready = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    // Shared timestamp model
    always @(posedge clk) ts_bus <= ts_load ? ts_val : ts_bus + 16'd1;

    dual_thr_hit_channel dut_i (
        .clk(clk), .rst_n(rst_n), .chan_id(chan_id),
        .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .ts_bus(ts_bus),
        .hit_word(hit_word), .hit_valid(hit_valid), .hit_ready(hit_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one pulse; returns the timestamp seen when cmp_lo rose
    task automatic pulse(input logic [15:0] preset, input int width, input int hi_at,
                         output logic [15:0] t0);
        @(negedge clk); ts_load = 1'b1; ts_val = preset;
        @(negedge clk); ts_load = 1'b0;
        t0 = ts_bus;
        cmp_lo = 1'b1;
        cmp_hi = (hi_at == 0);
        for (int i = 1; i < width; i++) begin
            @(negedge clk);
            cmp_hi = (i == hi_at);
        end
        @(negedge clk); cmp_lo = 1'b0; cmp_hi = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic accept();
        @(negedge clk); hit_ready = 1'b1;
        @(negedge clk); hit_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] t0, ta;
        int w, ex_tot;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, hit_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid after reset", {31'd0, hit_valid}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            w = int'(VEC[v].width);
            pulse(VEC[v].preset, w, int'(VEC[v].hi_at), t0);
            if (VEC[v].hi_at == 16'hFFFF) begin
                check("R6 unqualified pulse dropped", {31'd0, hit_valid}, 32'd0);
            end else begin
                ex_tot = (w > 1023) ? 1023 : w;
                check("R6 qualified pulse kept", {31'd0, hit_valid}, 32'd1);
                check("R7 chan field", {26'd0, hit_word[31:26]}, {26'd0, chan_id});
                check("R2 leading timestamp", {16'd0, hit_word[25:10]}, {16'd0, t0 + 16'd2});
                check(w > 1023 ? "R5 tot saturated" :
                      (VEC[v].preset > 16'hFF00 ? "R4 tot across wrap" : "R3 tot width"),
                      {22'd0, hit_word[9:0]}, ex_tot);
                ta = hit_word[25:10];
                repeat (3) @(negedge clk);
                check("R8 held valid", {31'd0, hit_valid}, 32'd1);
                check("R8 held lead", {16'd0, hit_word[25:10]}, {16'd0, ta});
                accept();
                check("R10 valid dropped", {31'd0, hit_valid}, 32'd0);
            end
        end

        // R9: pulse during pending is ignored
        chan_id = 6'h15;
        pulse(16'h0500, 6, 0, t0);
        ta = t0 + 16'd2;
        pulse(16'h0900, 8, 2, t0);
        check("R9 pending word kept", {16'd0, hit_word[25:10]}, {16'd0, ta});
        check("R9 pending chan", {26'd0, hit_word[31:26]}, 32'h15);
        check("R9 pending tot", {22'd0, hit_word[9:0]}, 32'd6);
        accept();
        repeat (10) @(negedge clk);
        check("R9 ignored pulse gives no word", {31'd0, hit_valid}, 32'd0);

        // R1: reset while pending
        pulse(16'h0A00, 4, 1, t0);
        check("R1 word pending before reset", {31'd0, hit_valid}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset clears pending", {31'd0, hit_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", {31'd0, hit_valid}, 32'd0);

        finish_run();
    end

endmodule